// File: doc/BRIEF.md
# Bicolour Link and Activity LED Driver

This block drives two bicolour status LEDs for an Ethernet port. One LED serves 10 Mb/s operation and the other 100 Mb/s. Each LED has two pins. Only the LED whose speed matches the current link speed lights. The colour shows the duplex mode: yellow for half duplex and green for full duplex. Receive activity makes the lit colour flash.

A one-cycle receive pulse opens a flash window of `WIN_CYC` clock cycles. During the window the colour alternates between dark and lit every `HALF_CYC` cycles, starting dark. A fresh pulse while the window is open extends the window. It does not restart the dark/lit rhythm. Both counts are parameters: the defaults suit a 25 MHz clock (80 ms window, 50 ms half period), and simulation uses short values.

Each of the four pins has its own polarity strap. The straps are sampled while reset is held, and the last sample before reset release is kept. A strap tied high makes its pin active low, and a strap tied low makes it active high. All pins are registered, so each pin follows its inputs one clock later.

Top module: `bicolor_link_led`

## Requirements
- R1: With `link_up` low, all four pins sit at their inactive level, whatever the other inputs do, including receive pulses.
- R2: A half-duplex link with no flash in progress shows steady yellow on the active pair. Yellow means pin A active and pin B inactive.
- R3: A full-duplex link with no flash in progress shows steady green on the active pair. Green means pin A inactive and pin B active.
- R4: `speed_100` high selects the 100 Mb/s pair (`led100_a`, `led100_b`), and low selects the 10 Mb/s pair (`led10_a`, `led10_b`). The unselected pair keeps both pins inactive.
- R5: The strap bits map as follows: bit 0 to `led10_a`, bit 1 to `led10_b`, bit 2 to `led100_a`, bit 3 to `led100_b`. A strap bit at 1 makes that pin active low (inactive level 1). A strap bit at 0 makes it active high (inactive level 0).
- R6: The strap value captured at the last clock edge with `rst_n` low is kept. Later changes on `strap_pins` have no effect on the pins.
- R7: Take a receive pulse sampled at edge P0 with no window open. The pins sampled after edge Pj show the state after P(j-1); call that step k = j-1. For k below `WIN_CYC`, the colour is lit when floor(k / `HALF_CYC`) is odd and dark otherwise. From k = `WIN_CYC` on, the colour is steady.
- R8: A pulse sampled at edge Pr while a window is open moves the window end to step r + `WIN_CYC`. The dark/lit rhythm keeps counting from P0.
- R9: While `rst_n` is low, each pin is driven to its inactive level for the current strap, from the clock edge after the strap is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low; straps are sampled while low |
| link_up | input | 1 | Link is established |
| speed_100 | input | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | input | 1 | 1 = full duplex, 0 = half duplex |
| rx_act | input | 1 | One-cycle receive activity pulse |
| strap_pins | input | 4 | Per-pin polarity straps, bit order as in R5 |
| led10_a | output | 1 | 10 Mb/s LED, pin A (yellow side) |
| led10_b | output | 1 | 10 Mb/s LED, pin B (green side) |
| led100_a | output | 1 | 100 Mb/s LED, pin A (yellow side) |
| led100_b | output | 1 | 100 Mb/s LED, pin B (green side) |

## Verification
A new receive pulse can coincide with the last cycle of an open flash window. In that cycle, expiry of the window and its extension compete. The bench provokes this by pulsing exactly on the edge where the remaining count is one. It then checks that the pins keep flashing in the unbroken rhythm and go steady only `WIN_CYC` steps after the second pulse. A second clash is a strap change in the same cycle as reset release: the bench changes the straps right after release and checks that the pin levels still follow the value held during reset.

// File: rtl/led_pkg.sv
package led_pkg;

  localparam int LED_PINS = 4;

  typedef enum logic [1:0] {
    COL_DARK   = 2'd0,
    COL_YELLOW = 2'd1,
    COL_GREEN  = 2'd2
  } led_colour_e;

  // Colour to show given link state and the blink phase.
  function automatic led_colour_e pick_colour(input logic link, input logic fdx,
                                              input logic lit);
    if (!link || !lit) return COL_DARK;
    return fdx ? COL_GREEN : COL_YELLOW;
  endfunction

  // Active flags of one pair, packed as {pin_b, pin_a}.
  function automatic logic [1:0] pair_drive(input led_colour_e c);
    case (c)
      COL_YELLOW: return 2'b01;
      COL_GREEN:  return 2'b10;
      default:    return 2'b00;
    endcase
  endfunction

  // Electrical level of a pin: a high strap inverts the sense.
  function automatic logic pin_level(input logic active, input logic strap);
    return active ^ strap;
  endfunction

endpackage

// File: rtl/led_strap_latch.sv
module led_strap_latch #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] strap_pins,
  output logic [NPIN-1:0] strap_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) strap_q <= strap_pins;
  end

  // R6: held value never moves once out of reset
  p_strap_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(strap_q));

endmodule

// File: rtl/led_blink_timer.sv
module led_blink_timer #(
  parameter int WIN_CYC  = 2_000_000,
  parameter int HALF_CYC = 1_250_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_act,
  output logic lit
);

  localparam int WW = $clog2(WIN_CYC + 1);
  localparam int HW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [WW-1:0] win_cnt;
  logic [HW-1:0] tog_cnt;
  logic          phase_on;

  logic flashing, win_start, win_extend, tog_wrap;
  assign flashing   = (win_cnt != '0);
  assign win_start  = rx_act && !flashing;
  assign win_extend = rx_act && flashing;
  assign tog_wrap   = flashing && (tog_cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      win_cnt  <= '0;
      tog_cnt  <= '0;
      phase_on <= 1'b0;
    end else begin
      if (rx_act)        win_cnt <= WW'(WIN_CYC);
      else if (flashing) win_cnt <= win_cnt - 1'b1;

      if (win_start) begin
        tog_cnt  <= HW'(HALF_CYC - 1);
        phase_on <= 1'b0;
      end else if (tog_wrap) begin
        tog_cnt  <= HW'(HALF_CYC - 1);
        phase_on <= !phase_on;
      end else if (flashing) begin
        tog_cnt  <= tog_cnt - 1'b1;
      end
    end
  end

  assign lit = !flashing || phase_on;

  // R7: a fresh window opens in the dark phase
  p_start_dark_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> (flashing && !phase_on));

  // R7: window closes after its last counted cycle when no pulse arrives
  p_expire_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flashing && !rx_act && win_cnt == WW'(1)) |=> !flashing);

  // R8: an extension leaves the rhythm alone
  p_extend_keeps_phase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (win_extend && tog_cnt != '0) |=> (flashing && phase_on == $past(phase_on)));

endmodule

// File: rtl/led_pin_stage.sv
module led_pin_stage #(
  parameter int NPIN = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] strap_live,
  input  logic [NPIN-1:0] strap_q,
  input  logic [NPIN-1:0] act,
  output logic [NPIN-1:0] pin_q
);

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    always_ff @(posedge clk) begin
      if (!rst_n) pin_q[i] <= strap_live[i];
      else        pin_q[i] <= led_pkg::pin_level(act[i], strap_q[i]);
    end
  end

endmodule

// File: rtl/bicolor_link_led.sv
module bicolor_link_led #(
  parameter int WIN_CYC  = 2_000_000,
  parameter int HALF_CYC = 1_250_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       link_up,
  input  logic       speed_100,
  input  logic       full_duplex,
  input  logic       rx_act,
  input  logic [3:0] strap_pins,
  output logic       led10_a,
  output logic       led10_b,
  output logic       led100_a,
  output logic       led100_b
);

  localparam int NPIN = led_pkg::LED_PINS;

  logic [NPIN-1:0] strap_q, act, pin_q, act_seen;
  logic            lit;
  logic [1:0]      pair_act;
  led_pkg::led_colour_e colour;

  led_strap_latch #(.NPIN(NPIN)) u_strap (
    .clk(clk), .rst_n(rst_n), .strap_pins(strap_pins), .strap_q(strap_q));

  led_blink_timer #(.WIN_CYC(WIN_CYC), .HALF_CYC(HALF_CYC)) u_blink (
    .clk(clk), .rst_n(rst_n), .rx_act(rx_act), .lit(lit));

  always_comb begin
    colour   = led_pkg::pick_colour(link_up, full_duplex, lit);
    pair_act = led_pkg::pair_drive(colour);
    act      = speed_100 ? {pair_act, 2'b00} : {2'b00, pair_act};
  end

  led_pin_stage #(.NPIN(NPIN)) u_pins (
    .clk(clk), .rst_n(rst_n), .strap_live(strap_pins), .strap_q(strap_q),
    .act(act), .pin_q(pin_q));

  assign {led100_b, led100_a, led10_b, led10_a} = pin_q;

  // Active flags as seen at the pins, recovered with the held straps
  assign act_seen = pin_q ^ strap_q;

  // R1: no link leaves every pin inactive
  p_nolink_dark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(link_up)) |-> (act_seen == '0));

  // R2: a pair never drives both of its pins
  p_pair_not_both_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (!(act_seen[0] && act_seen[1]) && !(act_seen[2] && act_seen[3])));

  // R3: steady full-duplex 10 Mb/s link shows green on the 10 Mb/s pair
  p_green_10_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(link_up && full_duplex && !speed_100 && lit))
      |-> (act_seen == 4'b0010));

  // R4: at most one pair is ever active
  p_one_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (act_seen[1:0] == 2'b00 || act_seen[3:2] == 2'b00));

endmodule

// File: tb/tb_bicolor_link_led.sv
module tb_bicolor_link_led;

  localparam int WIN  = 20;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_up = 1'b0, speed_100 = 1'b0, full_duplex = 1'b0, rx_act = 1'b0;
  logic [3:0] strap_pins = 4'b0000;
  logic       led10_a, led10_b, led100_a, led100_b;

  int checks = 0;
  int fails  = 0;
  logic [3:0] held_strap = 4'b0000;

  always #2 clk = ~clk;

  bicolor_link_led #(.WIN_CYC(WIN), .HALF_CYC(HALF)) dut (
    .clk(clk), .rst_n(rst_n), .link_up(link_up), .speed_100(speed_100),
    .full_duplex(full_duplex), .rx_act(rx_act), .strap_pins(strap_pins),
    .led10_a(led10_a), .led10_b(led10_b), .led100_a(led100_a), .led100_b(led100_b));

  function automatic logic [3:0] pins_now();
    return {led100_b, led100_a, led10_b, led10_a};
  endfunction

  // Expected pin levels restated from the requirements
  function automatic logic [3:0] expect_pins(input logic lk, input logic spd,
                                             input logic fdx, input logic on,
                                             input logic [3:0] st);
    logic [3:0] a;
    a = 4'b0000;
    if (lk && on) begin
      if (fdx) a[spd ? 3 : 1] = 1'b1;
      else     a[spd ? 2 : 0] = 1'b1;
    end
    for (int i = 0; i < 4; i++) a[i] = st[i] ? !a[i] : a[i];
    return a;
  endfunction

  task automatic chk(input logic [3:0] exp, input string req);
    checks++;
    if (pins_now() !== exp) begin
      fails++;
      $display("FAIL %s: pins=%b expected=%b at %0t", req, pins_now(), exp, $time);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(posedge clk);
    #1;
  endtask

  task automatic do_reset(input logic [3:0] st);
    rst_n = 1'b0; strap_pins = st; held_strap = st;
    link_up = 1'b0; rx_act = 1'b0;
    tick(3);
    chk(st, "R9 reset level");
    rst_n = 1'b1;
    tick(1);
  endtask

  task automatic set_link(input logic lk, input logic spd, input logic fdx);
    link_up = lk; speed_100 = spd; full_duplex = fdx;
    tick(2);
  endtask

  task automatic t_nolink();
    set_link(1'b0, 1'b1, 1'b1);
    chk(expect_pins(1'b0, 1'b1, 1'b1, 1'b1, held_strap), "R1 no link");
    rx_act = 1'b1; tick(1); rx_act = 1'b0;
    for (int j = 0; j < 6; j++) begin
      tick(1);
      chk(expect_pins(1'b0, 1'b1, 1'b1, 1'b1, held_strap), "R1 pulse without link");
    end
    tick(WIN + 2);
  endtask

  task automatic t_half_full();
    set_link(1'b1, 1'b0, 1'b0);
    chk(expect_pins(1'b1, 1'b0, 1'b0, 1'b1, held_strap), "R2 yellow 10M");
    set_link(1'b1, 1'b0, 1'b1);
    chk(expect_pins(1'b1, 1'b0, 1'b1, 1'b1, held_strap), "R3 green 10M");
  endtask

  task automatic t_speed();
    set_link(1'b1, 1'b1, 1'b0);
    chk(expect_pins(1'b1, 1'b1, 1'b0, 1'b1, held_strap), "R4 100M pair yellow");
    set_link(1'b1, 1'b1, 1'b1);
    chk(expect_pins(1'b1, 1'b1, 1'b1, 1'b1, held_strap), "R4 100M pair green");
    set_link(1'b1, 1'b0, 1'b0);
    chk(expect_pins(1'b1, 1'b0, 1'b0, 1'b1, held_strap), "R4 back to 10M pair");
  endtask

  // Flash run: pulse at P0, optional second pulse at edge Pr (0 = none)
  task automatic t_flash(input int r, input string req);
    int stop;
    int k;
    logic on;
    stop = WIN;
    rx_act = 1'b1; @(posedge clk); #1; rx_act = 1'b0;
    for (int j = 1; j <= ((r > 0) ? r + WIN : WIN) + 3; j++) begin
      if (j == r) rx_act = 1'b1;
      @(posedge clk); #1;
      rx_act = 1'b0;
      if (j == r) stop = r + WIN;
      k  = j - 1;
      on = (k >= stop) || (((k / HALF) % 2) == 1);
      chk(expect_pins(link_up, speed_100, full_duplex, on, held_strap), req);
    end
  endtask

  task automatic t_strap_ignored();
    do_reset(4'b0101);
    strap_pins = 4'b1010;
    set_link(1'b1, 1'b1, 1'b1);
    chk(expect_pins(1'b1, 1'b1, 1'b1, 1'b1, 4'b0101), "R6 strap change ignored");
    set_link(1'b1, 1'b0, 1'b0);
    chk(expect_pins(1'b1, 1'b0, 1'b0, 1'b1, 4'b0101), "R6 strap still held");
    chk(expect_pins(1'b1, 1'b0, 1'b0, 1'b1, 4'b0101), "R5 mixed polarity");
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset(4'b0000);
    t_nolink();
    t_half_full();
    t_speed();
    set_link(1'b1, 1'b0, 1'b0);
    t_flash(0, "R7 flash yellow");
    set_link(1'b1, 1'b1, 1'b1);
    t_flash(0, "R7 flash green 100M");
    t_flash(10, "R8 extend mid window");
    t_flash(WIN, "R8 extend on last cycle");
    do_reset(4'b1111);
    t_half_full();
    chk(expect_pins(1'b1, 1'b0, 1'b1, 1'b1, 4'b1111), "R5 active low green");
    t_flash(0, "R7 flash active low");
    t_nolink();
    t_strap_ignored();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule